// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block is a first-in first-out buffer whose write side and read side run on clocks with no fixed relation. Its storage depth is a power of two set by a parameter. Pointers cross between the two clock domains as Gray code through two-stage synchronisers. Master reset is asynchronous and active-low. While reset is held low, each port samples a mode input on its own clock. That sample decides how the two status flags behave until the next reset.

Standard mode hands out a word only when the reader asks for one. Fall-through mode moves the oldest word into the output register by itself. The flags then tell the reader whether the register holds valid data, and tell the writer whether there is room.

A mark input supports replaying a stretch of data. When the read clock first sees the mark high, the block records the position of the next word to be consumed. From then on the writer treats that position as the end of free space, so the marked data cannot be overwritten. Reading and writing carry on as usual. When the read clock first sees the mark low again, the read position jumps back to the recorded one and the block returns to normal operation.

Top module: `mark_fifo`

## Requirements
- R1: The mode is taken from `fwft_i` while `rst_ni` is low, with 0 meaning standard mode and 1 meaning fall-through mode. Right after reset in standard mode, `rflag_o`=0 (empty, active-low) and `wflag_o`=1 (not full, active-low). In fall-through mode, `rflag_o`=1 (no data) and `wflag_o`=0 (room).
- R2: In standard mode, every word, including the first one written into an empty buffer, reaches `rdata_o` only on a read-clock edge that performs a read. In fall-through mode, every word after the first needs a read. Words come out in the order they were written.
- R3: In fall-through mode, a word written into an empty buffer appears on `rdata_o` on the third read-clock rising edge after its write edge, and `rflag_o` falls on that same edge. No read request is needed.
- R4: A write attempted while the buffer is full (`wflag_o`=0 in standard mode, 1 in fall-through mode) is dropped, and the stored data is left intact.
- R5: A read happens only when `ren_ni` and `rcs_ni` are both low. A read request while the buffer is empty leaves `rdata_o` unchanged.
- R6: While `ren_ni` is high, `rdata_o` keeps its value. The single exception is the automatic load of fall-through mode when no valid word is held.
- R7: A flag driven by the other port changes on the second edge of its own clock after the causing edge. Empty clears on the second read-clock edge after a write, and full clears on the second write-clock edge after a read.
- R8: While `wcs_ni` is high, no data is written.
- R9: The read-clock edge that first samples `mark_i` high records the next unconsumed word as the mark. While the mark is held, the buffer reports full once the write position is a full depth ahead of the mark.
- R10: The read-clock edge that first samples `mark_i` low after a marked period moves the read position back to the mark. The next word delivered is the marked word.
- R11: Writes and reads proceed normally while the mark is held, and words written in that period are delivered in order after the rewind.
- R12: A new mark replaces any earlier one, and a rewind goes only to the most recent mark.
- R13: In fall-through mode, `rflag_o` rises on the read-clock edge that consumes the last stored word, and `rdata_o` keeps that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| fwft_i | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| wen_ni | input | 1 | Write enable, active low |
| wcs_ni | input | 1 | Write chip select, active low |
| wdata_i | input | DW | Write data |
| ren_ni | input | 1 | Read enable, active low |
| rcs_ni | input | 1 | Read chip select, active low |
| mark_i | input | 1 | Mark / retransmit hold, sampled on the read clock |
| rdata_o | output | DW | Registered read data |
| wflag_o | output | 1 | Full flag (standard, active low) or input-ready (fall-through, high blocks) |
| rflag_o | output | 1 | Empty flag (standard, active low) or output-ready (fall-through, high blocks) |

## Verification
Results that stay inside one domain are due at once. Read data, the empty flag after the last read, and full after a write are all valid one nanosecond after the causing edge. A flag that depends on the other port is probed twice: just after the first edge of its own clock, where it must not have moved yet, and just after the second edge, where it must have. A fall-through word is checked after the first, second and third read-clock edges that follow its write. The read clock runs 2 ns behind the write clock, so each of these edges can be placed exactly. Stimulus changes on falling edges, and the scoreboard monitor samples the read request at the rising edge and compares the data 2 ns later.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/mark_fifo_sync.sv
module mark_fifo_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/mark_fifo_mem.sv
module mark_fifo_mem #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mark_fifo_wr.sv
module mark_fifo_wr
  import mark_fifo_pkg::*;
#(
  parameter int AW = 4,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wen_ni,
  input  logic          wcs_ni,
  input  logic [PW-1:0] cgray_s_i,
  input  logic [PW-1:0] mgray_s_i,
  input  logic          mact_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_o,
  output logic          wflag_o
);
  fifo_mode_e    mode_q;
  logic [PW-1:0] wptr_q, wgray_q, wptr_n;
  logic [PW-1:0] cptr_b, mptr_b, limit, used;

  // mode is captured on every write-clock edge while reset is held
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(fwft_i);
  end

  always_comb begin
    cptr_b[PW-1] = cgray_s_i[PW-1];
    mptr_b[PW-1] = mgray_s_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      cptr_b[i] = cptr_b[i+1] ^ cgray_s_i[i];
      mptr_b[i] = mptr_b[i+1] ^ mgray_s_i[i];
    end
  end

  // a held mark becomes the end of free space
  assign limit  = mact_s_i ? mptr_b : cptr_b;
  assign used   = wptr_q - limit;
  assign full_o = (used == PW'(DEPTH));
  assign we_o   = !wen_ni && !wcs_ni && !full_o;
  assign wptr_n = wptr_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wptr_q  <= wptr_n;
      wgray_q <= wptr_n ^ (wptr_n >> 1);
    end
  end

  assign waddr_o = wptr_q[AW-1:0];
  assign wptr_o  = wptr_q;
  assign wgray_o = wgray_q;
  assign wflag_o = (mode_q == MODE_FWFT) ? full_o : !full_o;
endmodule

// File: rtl/mark_fifo_rd.sv
module mark_fifo_rd
  import mark_fifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          ren_ni,
  input  logic          rcs_ni,
  input  logic          mark_i,
  input  logic [PW-1:0] wgray_s_i,
  input  logic [DW-1:0] mem_q_i,
  output logic [AW-1:0] raddr_o,
  output logic [DW-1:0] rdata_o,
  output logic          rflag_o,
  output logic [PW-1:0] cgray_o,
  output logic [PW-1:0] mgray_o,
  output logic          mact_o,
  output logic          fwft_o
);
  fifo_mode_e    mode_q;
  logic [PW-1:0] rptr_q, rptr_n, mptr_q, wptr_b, cons, cons_n;
  logic          ov_q, ov_n, mark_q, mact_q, load;
  logic          fwft, rd_req, mem_empty, mark_rise, mark_fall;

  always_ff @(posedge rclk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(fwft_i);
  end

  always_comb begin
    wptr_b[PW-1] = wgray_s_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wptr_b[i] = wptr_b[i+1] ^ wgray_s_i[i];
  end

  assign fwft      = (mode_q == MODE_FWFT);
  assign rd_req    = !ren_ni && !rcs_ni;
  assign mem_empty = (wptr_b == rptr_q);
  assign mark_rise = mark_i && !mark_q;
  assign mark_fall = !mark_i && mark_q;
  // oldest word not yet consumed: the one at the output in fall-through mode
  assign cons      = (fwft && ov_q) ? rptr_q - PW'(1) : rptr_q;

  always_comb begin
    rptr_n = rptr_q;
    ov_n   = ov_q;
    load   = 1'b0;
    if (mark_fall) begin
      rptr_n = mptr_q;
      ov_n   = 1'b0;
    end else if (fwft) begin
      if ((!ov_q || rd_req) && !mem_empty) begin
        load   = 1'b1;
        rptr_n = rptr_q + PW'(1);
        ov_n   = 1'b1;
      end else if (rd_req && ov_q) begin
        ov_n = 1'b0;
      end
    end else if (rd_req && !mem_empty) begin
      load   = 1'b1;
      rptr_n = rptr_q + PW'(1);
    end
    cons_n = (fwft && ov_n) ? rptr_n - PW'(1) : rptr_n;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      ov_q    <= 1'b0;
      mark_q  <= 1'b0;
      mact_q  <= 1'b0;
      mptr_q  <= '0;
      mgray_o <= '0;
      cgray_o <= '0;
      rdata_o <= '0;
    end else begin
      rptr_q  <= rptr_n;
      ov_q    <= ov_n;
      mark_q  <= mark_i;
      cgray_o <= cons_n ^ (cons_n >> 1);
      if (load) rdata_o <= mem_q_i;
      if (mark_fall) begin
        mact_q <= 1'b0;
      end else if (mark_rise) begin
        mact_q  <= 1'b1;
        mptr_q  <= cons;
        mgray_o <= cons ^ (cons >> 1);
      end
    end
  end

  assign raddr_o = rptr_q[AW-1:0];
  assign rflag_o = fwft ? !ov_q : !mem_empty;
  assign mact_o  = mact_q;
  assign fwft_o  = fwft;
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wen_ni,
  input  logic          wcs_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_ni,
  input  logic          rcs_ni,
  input  logic          mark_i,
  output logic [DW-1:0] rdata_o,
  output logic          wflag_o,
  output logic          rflag_o
);
  localparam int PW = AW + 1;
  localparam int XW = 2 * PW + 1;

  logic          we, full, mact, mact_s, fwft_r;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr, wgray, wgray_s, cgray, cgray_s, mgray, mgray_s;
  logic [DW-1:0] mem_q;
  logic [XW-1:0] to_w, to_w_s;

  assign to_w = {mact, mgray, cgray};
  assign {mact_s, mgray_s, cgray_s} = to_w_s;

  mark_fifo_sync #(.W(XW)) u_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (to_w),
    .q_o   (to_w_s)
  );

  mark_fifo_sync #(.W(PW)) u_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_s)
  );

  mark_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .raddr_i(raddr),
    .rdata_o(mem_q)
  );

  mark_fifo_wr #(.AW(AW)) u_wr (
    .wclk_i   (wclk_i),
    .rst_ni   (rst_ni),
    .fwft_i   (fwft_i),
    .wen_ni   (wen_ni),
    .wcs_ni   (wcs_ni),
    .cgray_s_i(cgray_s),
    .mgray_s_i(mgray_s),
    .mact_s_i (mact_s),
    .we_o     (we),
    .waddr_o  (waddr),
    .wptr_o   (wptr),
    .wgray_o  (wgray),
    .full_o   (full),
    .wflag_o  (wflag_o)
  );

  mark_fifo_rd #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i   (rclk_i),
    .rst_ni   (rst_ni),
    .fwft_i   (fwft_i),
    .ren_ni   (ren_ni),
    .rcs_ni   (rcs_ni),
    .mark_i   (mark_i),
    .wgray_s_i(wgray_s),
    .mem_q_i  (mem_q),
    .raddr_o  (raddr),
    .rdata_o  (rdata_o),
    .rflag_o  (rflag_o),
    .cgray_o  (cgray),
    .mgray_o  (mgray),
    .mact_o   (mact),
    .fwft_o   (fwft_r)
  );
endmodule

// File: rtl/mark_fifo_chk.sv
module mark_fifo_chk #(
  parameter int DW = 16,
  parameter int AW = 4,
  localparam int PW = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wcs_ni,
  input logic          ren_ni,
  input logic          rflag_o,
  input logic [DW-1:0] rdata_o,
  input logic          full,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] mgray_s,
  input logic          mact_s,
  input logic          fwft_r
);
  logic [PW-1:0] mark_b;

  always_comb begin
    mark_b[PW-1] = mgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) mark_b[i] = mark_b[i+1] ^ mgray_s[i];
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full |=> $stable(wptr)); // R4
  AST_WCS_BLOCK: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wcs_ni |=> $stable(wptr)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!fwft_r && !rflag_o) |=> $stable(rdata_o)); // R5
  AST_OUT_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (ren_ni && (!fwft_r || !rflag_o)) |=> $stable(rdata_o)); // R6
  AST_MARK_LIMIT: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    mact_s |-> ((wptr - mark_b) <= PW'(DEPTH))); // R9
  AST_GRAY_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray ^ $past(wgray)) <= 1); // R7
endmodule

bind mark_fifo mark_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i (wclk_i),
  .rclk_i (rclk_i),
  .rst_ni (rst_ni),
  .wcs_ni (wcs_ni),
  .ren_ni (ren_ni),
  .rflag_o(rflag_o),
  .rdata_o(rdata_o),
  .full   (full),
  .wptr   (wptr),
  .wgray  (wgray),
  .mgray_s(mgray_s),
  .mact_s (mact_s),
  .fwft_r (fwft_r)
);

// File: tb/mark_fifo_test.sv
`timescale 1ns/1ps
module mark_fifo_test;
  logic        wclk = 1'b0, rclk = 1'b0;
  logic        rst_n = 1'b0, fwft = 1'b0;
  logic        wen_n = 1'b1, wcs_n = 1'b0, ren_n = 1'b1, rcs_n = 1'b0, mark = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        wflag, rflag;
  logic        mon_en = 1'b0;
  logic [15:0] mon_e;
  logic [15:0] exp_q[$];
  int          n_chk = 0, n_err = 0;

  mark_fifo uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft),
    .wen_ni(wen_n), .wcs_ni(wcs_n), .wdata_i(wdata),
    .ren_ni(ren_n), .rcs_ni(rcs_n), .mark_i(mark),
    .rdata_o(rdata), .wflag_o(wflag), .rflag_o(rflag)
  );

  always #4 wclk = ~wclk;
  initial begin
    #2;
    forever #4 rclk = ~rclk;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0;
    fwft  = m;
    repeat (3) @(posedge wclk);
    @(negedge wclk) rst_n = 1'b1;
    repeat (2) @(posedge rclk);
    #1;
  endtask

  // driver: one write, scoreboard push when the word is expected to land
  task automatic wr_word(input logic [15:0] d, input bit push);
    @(negedge wclk);
    wdata = d;
    wen_n = 1'b0;
    @(posedge wclk);
    #1 wen_n = 1'b1;
    if (push) exp_q.push_back(d);
  endtask

  task automatic rd_word();
    @(negedge rclk) ren_n = 1'b0;
    @(posedge rclk);
    #1 ren_n = 1'b1;
  endtask

  task automatic rd_chk(input logic [15:0] e, input string tag);
    rd_word();
    check(tag, 32'(rdata), 32'(e));
  endtask

  task automatic set_mark(input logic v);
    @(negedge rclk) mark = v;
    @(posedge rclk);
    #1;
  endtask

  // monitor: standard-mode reads are compared against the scoreboard
  always @(posedge rclk) begin
    if (mon_en && !ren_n && !rcs_n && rflag) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R2: read with empty scoreboard act=%0h exp=none", rdata);
      end else begin
        mon_e = exp_q.pop_front();
        #2;
        check("R2 scoreboard order", 32'(rdata), 32'(mon_e));
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    check("R1 std empty flag", 32'(rflag), 32'd0);
    check("R1 std full flag", 32'(wflag), 32'd1);
    check("R1 rdata reset", 32'(rdata), 32'd0);
    mon_en = 1'b1;

    wr_word(16'h1111, 1'b1);
    @(posedge rclk); #1;
    check("R7 empty held after 1st rclk edge", 32'(rflag), 32'd0);
    @(posedge rclk); #1;
    check("R7 empty clears on 2nd rclk edge", 32'(rflag), 32'd1);
    repeat (2) @(posedge rclk); #1;
    check("R2 no data without read", 32'(rdata), 32'd0);

    rcs_n = 1'b1;
    rd_word();
    check("R5 rcs high blocks read data", 32'(rdata), 32'd0);
    check("R5 rcs high keeps word", 32'(rflag), 32'd1);
    rcs_n = 1'b0;
    rd_word();
    #2;
    check("R5 empty after last read", 32'(rflag), 32'd0);
    rd_word();
    check("R5 read on empty ignored", 32'(rdata), 32'h1111);

    wcs_n = 1'b1;
    wr_word(16'h2222, 1'b0);
    repeat (3) @(posedge rclk); #1;
    check("R8 wcs high blocks write", 32'(rflag), 32'd0);
    wcs_n = 1'b0;

    for (int i = 0; i < 16; i++) begin
      wr_word(16'h3000 + 16'(i), 1'b1);
      if (i == 14) check("R4 not full one short", 32'(wflag), 32'd1);
    end
    check("R4 full after depth writes", 32'(wflag), 32'd0);
    wr_word(16'hDEAD, 1'b0);
    check("R4 still full", 32'(wflag), 32'd0);
    repeat (4) @(posedge rclk); #1;
    check("R6 output holds while ren high", 32'(rdata), 32'h1111);

    rd_word();
    @(posedge wclk); #1;
    check("R7 full held after 1st wclk edge", 32'(wflag), 32'd0);
    @(posedge wclk); #1;
    check("R7 full clears on 2nd wclk edge", 32'(wflag), 32'd1);
    for (int i = 0; i < 15; i++) rd_word();
    #3;
    check("R4 dropped word absent, empty", 32'(rflag), 32'd0);
    check("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    mon_en = 1'b0;

    // ---------------- mark / retransmit ----------------
    for (int i = 0; i < 4; i++) wr_word(16'hA000 + 16'(i), 1'b0);
    repeat (3) @(posedge rclk); #1;
    rd_chk(16'hA000, "R2 read before mark");
    set_mark(1'b1);
    rd_chk(16'hA001, "R11 read while marked");
    rd_chk(16'hA002, "R11 read while marked");
    repeat (3) @(posedge wclk);
    for (int i = 0; i < 13; i++) begin
      wr_word(16'hB000 + 16'(i), 1'b0);
      if (i == 11) check("R9 not full before mark limit", 32'(wflag), 32'd1);
    end
    check("R9 full at marked location", 32'(wflag), 32'd0);
    wr_word(16'hDEAD, 1'b0);
    rd_chk(16'hA003, "R11 read continues in retransmit");
    set_mark(1'b0);
    rd_chk(16'hA001, "R10 rewind to mark");
    rd_chk(16'hA002, "R10 replay");
    rd_chk(16'hA003, "R10 replay");
    for (int i = 0; i < 13; i++) rd_chk(16'hB000 + 16'(i), "R11 marked-period writes kept");
    check("R9 blocked write absent", 32'(rflag), 32'd0);

    for (int i = 0; i < 4; i++) wr_word(16'hC000 + 16'(i), 1'b0);
    repeat (3) @(posedge rclk); #1;
    set_mark(1'b1);
    rd_chk(16'hC000, "R2 read after mark");
    set_mark(1'b0);
    rd_chk(16'hC000, "R10 rewind");
    rd_chk(16'hC001, "R10 replay");
    rd_chk(16'hC002, "R10 replay");
    set_mark(1'b1);
    rd_chk(16'hC003, "R12 read after new mark");
    set_mark(1'b0);
    rd_chk(16'hC003, "R12 rewind to latest mark");
    check("R12 empty after latest replay", 32'(rflag), 32'd0);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    check("R1 fwft output-ready flag", 32'(rflag), 32'd1);
    check("R1 fwft input-ready flag", 32'(wflag), 32'd0);
    wr_word(16'hD000, 1'b0);
    @(posedge rclk); #1;
    check("R3 not ready after 1st edge", 32'(rflag), 32'd1);
    @(posedge rclk); #1;
    check("R3 not ready after 2nd edge", 32'(rflag), 32'd1);
    @(posedge rclk); #1;
    check("R3 ready on 3rd edge", 32'(rflag), 32'd0);
    check("R3 word fell through", 32'(rdata), 32'hD000);
    wr_word(16'hD001, 1'b0);
    repeat (3) @(posedge rclk); #1;
    check("R6 fwft output holds", 32'(rdata), 32'hD000);
    rd_chk(16'hD001, "R2 fwft next word needs read");
    check("R2 fwft still ready", 32'(rflag), 32'd0);
    rd_word();
    check("R13 flag rises on last consume", 32'(rflag), 32'd1);
    check("R13 last word kept", 32'(rdata), 32'hD001);
    rd_word();
    check("R5 fwft read on empty ignored", 32'(rdata), 32'hD001);

    for (int i = 0; i < 16; i++) begin
      wr_word(16'hE000 + 16'(i), 1'b0);
      if (i == 14) check("R4 fwft room one short", 32'(wflag), 32'd0);
    end
    check("R4 fwft full", 32'(wflag), 32'd1);
    wr_word(16'hDEAD, 1'b0);
    repeat (3) @(posedge rclk); #1;
    check("R3 first of burst fell through", 32'(rdata), 32'hE000);
    rd_chk(16'hE001, "R2 fwft read");
    @(posedge wclk); #1;
    check("R7 input-ready held after 1st wclk edge", 32'(wflag), 32'd1);
    @(posedge wclk); #1;
    check("R7 input-ready clears on 2nd wclk edge", 32'(wflag), 32'd0);
    for (int i = 2; i < 16; i++) rd_chk(16'hE000 + 16'(i), "R4 fwft order kept");
    rd_word();
    check("R13 flag rises after drain", 32'(rflag), 32'd1);
    check("R4 dropped word absent", 32'(rdata), 32'hE00F);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule